// File: doc/BRIEF.md
# Reference Period and Phase Tracking Controller

This block keeps a free-running pulse generator locked to a slow external reference. The reference is typically about 1 Hz and the generator produces many output pulses per reference period. The block never produces the pulse train itself. It watches a one-cycle pulse that marks each synchronized reference rising edge and the level of the generated train. From these it produces a half-period value, given in timebase cycles, that the generator loads whenever the update strobe fires.

Each reference interval gives two measurements. The first is the reference period, counted in timebase cycles between successive reference edges. The second is the phase separation, counted from a reference edge to the first falling edge of the generated train after it. The nominal half-period is the period divided by twice the configured pulse ratio. The phase error is the current half-period minus the measured separation. A damped, bounded share of that error is added to the nominal value, so the next measurement should land close to zero error without overshoot.

The block guards against a bad reference. If the reference goes missing, the current measurement is discarded and a flag is raised. If a period differs too much from the last good one, the period is rejected. In both cases the half-period is left untouched.

Top module: `ref_track_ctrl`

## Requirements
- R1: The reference period is the number of clock cycles between two successive `ref_edge` pulses. The first edge after reset, and the first edge after a discarded measurement, only start a new measurement and produce no update.
- R2: For an accepted period P, the nominal half-period is floor(P / (2·N)), where N is `ratio`, and a `ratio` of 0 is treated as 1. The first accepted period after reset applies no phase correction.
- R3: `hp_update` is high for exactly one cycle. It rises CNT_W+1 cycles after the clock edge that sampled the accepting `ref_edge`. `half_period` changes only in the cycle in which `hp_update` is high.
- R4: The phase separation is the number of cycles from the clock edge that sampled `ref_edge` to the first later edge that samples `gen_out` low after sampling it high on the edge before. Only the first such falling edge in each reference interval is kept.
- R5: On an accepted edge, if a separation S was captured in the interval just ended and a half-period H is already in effect, the block computes the error E = H − S. The correction is E arithmetically shifted right by CORR_SHIFT, clamped to ±MAX_STEP, and added to the nominal value. If no falling edge was captured, the correction is zero.
- R6: Once a valid period L is known, a measurement is discarded if more than L + floor(L/2) cycles pass without a reference edge. When that happens, `ref_missing` is set and no update follows. An edge arriving exactly L + floor(L/2) + 1 cycles after the previous edge is still evaluated as a period.
- R7: A period P with |P − L| > floor(L/8) is rejected. On a rejection `ref_outlier` is set, no update follows, and L is kept unchanged. A difference of exactly floor(L/8) is accepted.
- R8: `ref_missing` and `ref_outlier` are both cleared by the next accepted period.
- R9: The loaded half-period never falls below 2 and saturates at the all-ones value of CNT_W bits.
- R10: After reset, `half_period` is 0 and `hp_update`, `ref_missing` and `ref_outlier` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ref_edge | input | 1 | One-cycle pulse for each synchronized reference rising edge |
| gen_out | input | 1 | Level of the generated pulse train |
| ratio | input | RATIO_W | Output pulses per reference period (0 is treated as 1) |
| half_period | output | CNT_W | Half-period for the pulse generator, in clock cycles |
| hp_update | output | 1 | One-cycle strobe marking a newly loaded `half_period` |
| ref_missing | output | 1 | Set when a reference edge failed to arrive in time |
| ref_outlier | output | 1 | Set when a measured period was rejected |

## Verification
The bench runs a sweep of phase separations from well below to well above the half-period in effect. This separates the zero-error case, the small damped corrections, and both clamped extremes, and intervals with no falling edge confirm the zero-correction path. Changes of the pulse ratio, including 0 and a value large enough to hit the floor of 2, separate the nominal division from the correction. A chain of periods placed exactly on and one cycle past the outlier tolerance, then on and one past the timeout limit, tells apart acceptance, rejection, a late but still measured edge, and a discarded measurement, each with its flag pattern.

// File: rtl/ref_track_pkg.sv
package ref_track_pkg;

  // Measurement progress of the reference period counter
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,  // no reference edge seen yet
    ST_FIRST = 2'd1,  // counting, no valid period known
    ST_TRACK = 2'd2,  // counting, valid period known
    ST_LOST  = 2'd3   // valid period known, running measurement discarded
  } meas_state_e;

endpackage

// File: rtl/ref_track_meas.sv
module ref_track_meas
  import ref_track_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_edge,
  input  logic             gen_out,
  output logic [CNT_W-1:0] period,
  output logic             accept,
  output logic             reject,
  output logic             timeout,
  output logic [CNT_W-1:0] ph_sep,
  output logic             ph_valid
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  meas_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] last_q, last_d;
  logic             last_en;
  logic [CNT_W-1:0] ph_cnt_q, ph_cnt_d;
  logic             ph_arm_q, ph_arm_d;
  logic [CNT_W-1:0] ph_sep_q, ph_sep_d;
  logic             ph_val_q, ph_val_d;
  logic             gen_d_q;

  logic [CNT_W:0]   limit;
  logic [CNT_W-1:0] tol;
  logic [CNT_W-1:0] diff;
  logic             in_tol;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] ph_inc;
  logic             gen_fall;

  // window and tolerance derived from last accepted period
  always_comb begin
    limit   = {1'b0, last_q} + {2'b00, last_q[CNT_W-1:1]};
    tol     = {3'b000, last_q[CNT_W-1:3]};
    diff    = (cnt_q >= last_q) ? (cnt_q - last_q) : (last_q - cnt_q);
    in_tol  = (diff <= tol);
    cnt_inc = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_ONE;
    ph_inc  = (ph_cnt_q == CNT_MAX) ? ph_cnt_q : ph_cnt_q + CNT_ONE;
    gen_fall = gen_d_q & ~gen_out;
  end

  // period measurement next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    last_d  = cnt_q;
    last_en = 1'b0;
    accept  = 1'b0;
    reject  = 1'b0;
    timeout = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_edge) begin
          state_d = ST_FIRST;
          cnt_d   = CNT_ONE;
        end
      end
      ST_FIRST: begin
        if (ref_edge) begin
          accept  = 1'b1;
          last_en = 1'b1;
          state_d = ST_TRACK;
          cnt_d   = CNT_ONE;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      ST_TRACK: begin
        if (ref_edge) begin
          cnt_d = CNT_ONE;
          if (in_tol) begin
            accept  = 1'b1;
            last_en = 1'b1;
          end else begin
            reject = 1'b1;
          end
        end else if ({1'b0, cnt_q} > limit) begin
          timeout = 1'b1;
          state_d = ST_LOST;
        end else begin
          cnt_d = cnt_inc;
        end
      end
      ST_LOST: begin
        if (ref_edge) begin
          state_d = ST_TRACK;
          cnt_d   = CNT_ONE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // phase separation next state
  always_comb begin
    ph_cnt_d = ph_cnt_q;
    ph_arm_d = ph_arm_q;
    ph_sep_d = ph_sep_q;
    ph_val_d = ph_val_q;
    if (ref_edge) begin
      ph_cnt_d = CNT_ONE;
      ph_arm_d = 1'b1;
      ph_val_d = 1'b0;
    end else if (ph_arm_q && gen_fall) begin
      ph_sep_d = ph_cnt_q;
      ph_val_d = 1'b1;
      ph_arm_d = 1'b0;
    end else if (ph_arm_q) begin
      ph_cnt_d = ph_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      last_q   <= '0;
      ph_cnt_q <= '0;
      ph_arm_q <= 1'b0;
      ph_sep_q <= '0;
      ph_val_q <= 1'b0;
      gen_d_q  <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      if (last_en) begin
        last_q <= last_d;
      end
      ph_cnt_q <= ph_cnt_d;
      ph_arm_q <= ph_arm_d;
      ph_sep_q <= ph_sep_d;
      ph_val_q <= ph_val_d;
      gen_d_q  <= gen_out;
    end
  end

  assign period   = cnt_q;
  assign ph_sep   = ph_sep_q;
  assign ph_valid = ph_val_q;

endmodule

// File: rtl/ref_track_div.sv
module ref_track_div #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num,
  input  logic [W:0]   den,
  output logic [W-1:0] quot,
  output logic         done
);

  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] STEPS = CW'(W);
  localparam logic [CW-1:0] ONE   = CW'(1);

  logic [W:0]    rem_q, rem_d;
  logic [W-1:0]  q_q, q_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;
  logic [W:0]    rem_sh;
  logic          fits;

  // one restoring step per cycle, MSB first
  always_comb begin
    rem_sh = {rem_q[W-1:0], q_q[W-1]};
    fits   = (rem_sh >= den);
    rem_d  = rem_q;
    q_d    = q_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    if (start) begin
      rem_d = '0;
      q_d   = num;
      cnt_d = STEPS;
    end else if (cnt_q != '0) begin
      rem_d  = fits ? (rem_sh - den) : rem_sh;
      q_d    = {q_q[W-2:0], fits};
      cnt_d  = cnt_q - ONE;
      done_d = (cnt_q == ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      q_q    <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      q_q    <= q_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign quot = q_q;
  assign done = done_q;

endmodule

// File: rtl/ref_track_corr.sv
module ref_track_corr #(
  parameter int W        = 20,
  parameter int SHIFT    = 6,
  parameter int MAX_STEP = 4
) (
  input  logic                hp,
  input  logic [W-1:0]        hp_val,
  input  logic [W-1:0]        sep,
  input  logic                sep_ok,
  output logic signed [W+1:0] corr
);

  localparam logic signed [W+1:0] STEP_P = (W+2)'(MAX_STEP);
  localparam logic signed [W+1:0] STEP_N = -STEP_P;

  logic signed [W+1:0] err;
  logic signed [W+1:0] damped;

  always_comb begin
    err    = $signed({2'b00, hp_val}) - $signed({2'b00, sep});
    damped = err >>> SHIFT;
    if (!(hp && sep_ok)) begin
      corr = '0;
    end else if (damped > STEP_P) begin
      corr = STEP_P;
    end else if (damped < STEP_N) begin
      corr = STEP_N;
    end else begin
      corr = damped;
    end
  end

endmodule

// File: rtl/ref_track_ctrl.sv
module ref_track_ctrl #(
  parameter int CNT_W      = 20,
  parameter int RATIO_W    = 8,
  parameter int CORR_SHIFT = 6,
  parameter int MAX_STEP   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_edge,
  input  logic               gen_out,
  input  logic [RATIO_W-1:0] ratio,
  output logic [CNT_W-1:0]   half_period,
  output logic               hp_update,
  output logic               ref_missing,
  output logic               ref_outlier
);

  localparam logic signed [CNT_W+1:0] HP_MIN = (CNT_W+2)'(2);
  localparam logic signed [CNT_W+1:0] HP_MAX = $signed({2'b00, {CNT_W{1'b1}}});
  localparam int PAD_W = CNT_W - RATIO_W;

  logic               rst_meta_q, rst_sync_n;
  logic [CNT_W-1:0]   period;
  logic               accept, reject, timeout;
  logic [CNT_W-1:0]   ph_sep;
  logic               ph_valid;
  logic [CNT_W:0]     den;
  logic [CNT_W-1:0]   quot;
  logic               div_done;
  logic signed [CNT_W+1:0] corr_w;
  logic signed [CNT_W+1:0] corr_q;
  logic signed [CNT_W+1:0] sum;
  logic [CNT_W-1:0]   hp_next;
  logic               hp_valid_q;
  logic               miss_d, outl_d;

  // reset: asserted at once, released on clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  ref_track_meas #(.CNT_W(CNT_W)) u_meas (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ref_edge (ref_edge),
    .gen_out  (gen_out),
    .period   (period),
    .accept   (accept),
    .reject   (reject),
    .timeout  (timeout),
    .ph_sep   (ph_sep),
    .ph_valid (ph_valid)
  );

  always_comb begin
    if (ratio == '0) begin
      den = (CNT_W+1)'(2);
    end else begin
      den = {{PAD_W{1'b0}}, ratio, 1'b0};
    end
  end

  ref_track_div #(.W(CNT_W)) u_div (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .start (accept),
    .num   (period),
    .den   (den),
    .quot  (quot),
    .done  (div_done)
  );

  ref_track_corr #(
    .W        (CNT_W),
    .SHIFT    (CORR_SHIFT),
    .MAX_STEP (MAX_STEP)
  ) u_corr (
    .hp     (hp_valid_q),
    .hp_val (half_period),
    .sep    (ph_sep),
    .sep_ok (ph_valid),
    .corr   (corr_w)
  );

  // final half-period with floor and saturation
  always_comb begin
    sum = $signed({2'b00, quot}) + corr_q;
    if (sum < HP_MIN) begin
      hp_next = CNT_W'(2);
    end else if (sum > HP_MAX) begin
      hp_next = '1;
    end else begin
      hp_next = sum[CNT_W-1:0];
    end
    miss_d = ref_missing;
    outl_d = ref_outlier;
    if (accept) begin
      miss_d = 1'b0;
      outl_d = 1'b0;
    end else begin
      if (timeout) miss_d = 1'b1;
      if (reject)  outl_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      corr_q      <= '0;
      half_period <= '0;
      hp_valid_q  <= 1'b0;
      hp_update   <= 1'b0;
      ref_missing <= 1'b0;
      ref_outlier <= 1'b0;
    end else begin
      if (accept) begin
        corr_q <= corr_w;
      end
      if (div_done) begin
        half_period <= hp_next;
        hp_valid_q  <= 1'b1;
      end
      hp_update   <= div_done;
      ref_missing <= miss_d;
      ref_outlier <= outl_d;
    end
  end

endmodule

// File: rtl/ref_track_ctrl_chk.sv
module ref_track_ctrl_chk #(
  parameter int CNT_W    = 20,
  parameter int MAX_STEP = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    hp_update,
  input logic [CNT_W-1:0]        half_period,
  input logic                    reject,
  input logic                    ref_outlier,
  input logic signed [CNT_W+1:0] corr_q
);

  localparam logic signed [CNT_W+1:0] LIM_P = (CNT_W+2)'(MAX_STEP);
  localparam logic signed [CNT_W+1:0] LIM_N = -LIM_P;

  // R3
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hp_update |=> !hp_update);

  // R3
  hp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hp_update |-> $stable(half_period));

  // R9
  hp_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hp_update |-> (half_period >= CNT_W'(2)));

  // R5
  corr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_q <= LIM_P) && (corr_q >= LIM_N));

  // R7
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> !hp_update);

  // R7
  outlier_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> ref_outlier);

endmodule

bind ref_track_ctrl ref_track_ctrl_chk #(
  .CNT_W    (CNT_W),
  .MAX_STEP (MAX_STEP)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .hp_update   (hp_update),
  .half_period (half_period),
  .reject      (reject),
  .ref_outlier (ref_outlier),
  .corr_q      (corr_q)
);

// File: tb/ref_track_ctrl_test.sv
module ref_track_ctrl_test;

  localparam int CW = 20;
  localparam int RW = 8;
  localparam int SH = 2;
  localparam int MS = 4;

  logic          clk;
  logic          rst_n;
  logic          ref_edge;
  logic          gen_out;
  logic [RW-1:0] ratio;
  logic [CW-1:0] half_period;
  logic          hp_update;
  logic          ref_missing;
  logic          ref_outlier;

  ref_track_ctrl #(
    .CNT_W(CW), .RATIO_W(RW), .CORR_SHIFT(SH), .MAX_STEP(MS)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .gen_out(gen_out),
    .ratio(ratio), .half_period(half_period), .hp_update(hp_update),
    .ref_missing(ref_missing), .ref_outlier(ref_outlier)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  finished = 0;

  // reference model state
  int  st = 0;        // 0 idle, 1 first, 2 track, 3 lost
  int  last_p = 0;
  int  hp_m = 0;
  bit  hpv = 0;
  bit  miss_m = 0;
  bit  outl_m = 0;
  int  prev_p = 0;
  int  prev_s = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one reference interval of p cycles; gen_out falls at offset s (0: no fall)
  task automatic run_iv(input int p, input int s);
    bit    exp_upd = 0;
    bit    used_corr = 0;
    int    r;
    int    q;
    int    c;
    int    e;
    int    v;
    int    n_upd = 0;
    int    k_upd = -1;
    int    v_upd = 0;
    int    hp_prev;
    int    first_st;
    // model: timeout in the interval just ended, then edge evaluation
    if (st == 2 && prev_p >= last_p + last_p / 2 + 2) begin
      miss_m = 1;
      st = 3;
    end
    first_st = st;
    case (st)
      0: st = 1;
      3: st = 2;
      default: begin
        e = prev_p - last_p;
        if (e < 0) e = -e;
        if (st == 1 || e <= last_p / 8) begin
          r = (ratio == 0) ? 1 : int'(ratio);
          q = prev_p / (2 * r);
          c = 0;
          if (hpv && prev_s > 0) begin
            c = (hp_m - prev_s) >>> SH;
            if (c > MS) c = MS;
            if (c < -MS) c = -MS;
            used_corr = 1;
          end
          v = q + c;
          if (v < 2) v = 2;
          hp_m = v;
          hpv = 1;
          last_p = prev_p;
          miss_m = 0;
          outl_m = 0;
          st = 2;
          exp_upd = 1;
        end else begin
          outl_m = 1;
        end
      end
    endcase
    hp_prev = int'(half_period);
    for (int k = 0; k < p; k++) begin
      @(negedge clk);
      if (k >= 1) begin
        if (hp_update) begin
          n_upd++;
          k_upd = k;
          v_upd = int'(half_period);
        end else if (int'(half_period) != hp_prev) begin
          chk(0, "R3 hold", half_period, hp_prev);
        end
        hp_prev = int'(half_period);
        if (k == 1) begin
          chk(ref_missing == miss_m, "R6/R8 missing flag", ref_missing, miss_m);
          chk(ref_outlier == outl_m, "R7/R8 outlier flag", ref_outlier, outl_m);
        end
      end
      ref_edge = (k == 0);
      gen_out  = (s > 0) && (k < s);
    end
    if (first_st == 0 || first_st == 3)
      chk(n_upd == 0, "R1 start edge no update", n_upd, 0);
    else
      chk(n_upd == int'(exp_upd), "R3 update count", n_upd, exp_upd);
    if (exp_upd) begin
      chk(k_upd == CW + 2, "R3 strobe latency", k_upd, CW + 2);
      if (used_corr)
        chk(v_upd == hp_m, "R4/R5 corrected half-period", v_upd, hp_m);
      else
        chk(v_upd == hp_m, "R2/R9 nominal half-period", v_upd, hp_m);
    end else begin
      chk(int'(half_period) == hp_m, "R6/R7 half-period kept", half_period, hp_m);
    end
    prev_p = p;
    prev_s = s;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    rst_n    = 1'b0;
    ref_edge = 1'b0;
    gen_out  = 1'b0;
    ratio    = RW'(4);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(half_period == '0, "R10 half_period", half_period, 0);
    chk(hp_update == 1'b0, "R10 hp_update", hp_update, 0);
    chk(ref_missing == 1'b0, "R10 ref_missing", ref_missing, 0);
    chk(ref_outlier == 1'b0, "R10 ref_outlier", ref_outlier, 0);

    // R1 start, R2 first estimate
    run_iv(800, 0);
    run_iv(800, 0);
    // R4 R5 sweep of separations around the half-period
    for (int s = 60; s <= 140; s += 8) run_iv(800, s);
    run_iv(800, 0);
    run_iv(800, 0);
    // R2 ratio variants
    ratio = RW'(3);
    run_iv(801, 0);
    ratio = RW'(0);
    run_iv(800, 0);
    ratio = RW'(255);
    run_iv(800, 0);
    // R9 floor reached by the previous evaluation
    ratio = RW'(4);
    run_iv(800, 0);
    // R7 tolerance boundary, R6 timeout boundary
    run_iv(900, 0);
    run_iv(1013, 0);
    run_iv(788, 0);
    run_iv(1183, 0);
    run_iv(1184, 0);
    run_iv(790, 0);
    run_iv(790, 96);
    run_iv(800, 0);
    run_iv(100, 0);
    summary();
  end

endmodule